// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Per-Operand Sign Modes

This block is a fixed-point multiplier-accumulator. It takes two 16-bit operands and a 5-bit function code. From these it forms a product, and then does one of three things with it: loads it, adds it to the 40-bit accumulator, or subtracts it from the accumulator. The accumulator has three parts: an 8-bit guard byte, a 16-bit middle word and a 16-bit low word. The middle word is the main result that the rest of the datapath reads.

The function code carries two pieces of information. The first is the kind of operation. The second is how each operand is read, either as two's complement or as unsigned. Three codes give rounded forms, and these treat both operands as signed. A mode input picks the product alignment:

- In fractional alignment the product moves up one bit before it is used.
- In integer alignment the product is used as it is.

A destination input sends the middle word of the result to a separate 16-bit feedback register instead of the accumulator. The unit reports when the accumulator value no longer fits in 32 signed bits.

Top module: `mac_unit`

## Requirements
- R1: During reset and on the first cycle after it, all accumulator parts, the feedback word and the overflow flag read zero.
- R2: A function code of 00000, or any code whose bit 4 is 1, changes no output on the following cycle.
- R3: Codes 00001, 00010 and 00011 each treat both operands as two's complement and then round the result. Their operations are:
  - 00001 loads X·Y.
  - 00010 computes ACC+X·Y.
  - 00011 computes ACC−X·Y.
- R4: Codes with bit 4 = 0 and bits [3:2] ≠ 00 work as follows:
  - Bits [3:2] pick the operation: 01 loads X·Y, 10 adds it to ACC, 11 subtracts it from ACC.
  - Bit 1 = 0 makes X two's complement and bit 1 = 1 makes X unsigned.
  - Bit 0 does the same for Y.
  - These codes never round.
- R5: An unsigned operand counts as 0 to 65535. The product is sign-extended to 40 bits, so an unsigned-by-unsigned product is never negative.
- R6: When the integer-mode input is 0, the product is shifted left by one bit before it is used. When the input is 1, the product is not shifted.
- R7: Rounding adds 0x8000 to the 40-bit result. If the low 16 bits of the result were exactly 0x8000 before the add, bit 16 of the rounded value is then cleared, which rounds a tie to an even middle word.
- R8: The overflow flag is updated each time the accumulator is written. It is 1 when bits 39 down to 31 of the new value are not all equal.
- R9: When the destination input is 1, bits 31:16 of the result go to the feedback word. The accumulator and the overflow flag keep their values, and accumulating codes still read the accumulator.
- R10: The accumulator parts are mapped as high = bits 39:32, middle = bits 31:16 and low = bits 15:0. The outputs show an operation's effect from the first clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| func_in | input | 5 | Function code |
| int_mode_in | input | 1 | 1 = integer alignment, 0 = fractional |
| dest_fb_in | input | 1 | 1 = write the result's middle word to the feedback register |
| acc_hi_o | output | 8 | Accumulator guard byte |
| acc_mid_o | output | 16 | Accumulator middle word |
| acc_lo_o | output | 16 | Accumulator low word |
| fb_o | output | 16 | Feedback register |
| ovf_o | output | 1 | Accumulator overflow flag |

## Verification
The bench uses the operands 0xFFFF and 0x8000 with all four signedness codes. This tells the signed and unsigned readings of each operand apart, and shows whether X and Y have been swapped.

Running the same operands in integer and fractional mode shows whether the alignment shift is applied. Chains of adds and subtracts then carry the result into the guard byte and back out.

Rounding uses three cases with known answers:
- a tie with an odd middle word,
- a tie with an even middle word,
- a value that is not a tie.

These cases separate round-to-even from plain round-half-up. Idle codes, arithmetic/logic codes and feedback-destination writes are each followed by a readback. The readback shows that the accumulator was not touched.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_MUL  = 2'b01,
        OP_ADD  = 2'b10,
        OP_SUB  = 2'b11
    } mac_op_e;

    typedef struct packed {
        mac_op_e op;
        logic    x_signed;
        logic    y_signed;
        logic    round;
    } mac_dec_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
(
    input  logic [4:0] func_i,
    output mac_dec_t   dec_o
);

    always_comb begin
        dec_o = '{op: OP_IDLE, x_signed: 1'b0, y_signed: 1'b0, round: 1'b0};
        if (!func_i[4]) begin
            if (func_i[3:2] == 2'b00) begin
                // rounded group: both operands two's complement (R3)
                dec_o.op       = mac_op_e'(func_i[1:0]);
                dec_o.x_signed = 1'b1;
                dec_o.y_signed = 1'b1;
                dec_o.round    = (func_i[1:0] != 2'b00);
            end else begin
                // sign-mode group (R4)
                dec_o.op       = mac_op_e'(func_i[3:2]);
                dec_o.x_signed = !func_i[1];
                dec_o.y_signed = !func_i[0];
            end
        end
    end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  logic          x_signed_i,
    input  logic          y_signed_i,
    input  logic          frac_i,
    output logic [AW-1:0] prod_o
);

    localparam int PW = 2 * DW + 2;

    logic signed [DW:0]   x_ext;
    logic signed [DW:0]   y_ext;
    logic signed [PW-1:0] raw;
    logic [AW-1:0]        wide;

    always_comb begin
        x_ext  = {x_signed_i & x_i[DW-1], x_i};
        y_ext  = {y_signed_i & y_i[DW-1], y_i};
        raw    = x_ext * y_ext;
        wide   = {{(AW - PW){raw[PW-1]}}, raw};
        prod_o = frac_i ? {wide[AW-2:0], 1'b0} : wide;
    end

    // R5: unsigned by unsigned never yields a negative product
    always_comb begin
        if (!x_signed_i && !y_signed_i && !frac_i) begin
            a_uu_nonneg_r5: assert (!prod_o[AW-1]);
        end
    end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] prod_i,
    input  mac_op_e       op_i,
    input  logic          round_i,
    output logic [AW-1:0] res_o,
    output logic          ovf_o
);

    localparam int          TOPB = 2 * DW - 1;
    localparam logic [AW-1:0] HALF = AW'(1) << (DW - 1);

    logic [AW-1:0]        sum;
    logic [AW-1:0]        bumped;
    logic                 tie;
    logic [AW-1:TOPB]     top;
    logic signed [AW-1:0] rdiff;

    always_comb begin
        unique case (op_i)
            OP_ADD:  sum = acc_i + prod_i;
            OP_SUB:  sum = acc_i - prod_i;
            default: sum = prod_i;
        endcase
        tie    = (sum[DW-1:0] == HALF[DW-1:0]);
        bumped = sum + HALF;
        if (tie) begin
            bumped[DW] = 1'b0;
        end
        res_o = round_i ? bumped : sum;
        top   = res_o[AW-1:TOPB];
        ovf_o = !((&top) || !(|top));
        rdiff = $signed(res_o - sum);
    end

    // R7: rounding moves the value by at most half an LSB of the middle word
    always_comb begin
        if (round_i) begin
            a_round_bound_r7: assert (rdiff <= $signed(HALF) && rdiff >= -$signed(HALF));
        end
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int DW = 16,
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic [4:0]    func_in,
    input  logic          int_mode_in,
    input  logic          dest_fb_in,
    output logic [GW-1:0] acc_hi_o,
    output logic [DW-1:0] acc_mid_o,
    output logic [DW-1:0] acc_lo_o,
    output logic [DW-1:0] fb_o,
    output logic          ovf_o
);

    localparam int AW = GW + 2 * DW;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [DW-1:0] fb;
        logic          ovf;
    } mac_state_t;

    mac_state_t    st_d, st_q;
    mac_dec_t      dec;
    logic [AW-1:0] prod;
    logic [AW-1:0] res;
    logic          res_ovf;

    mac_decode u_dec (
        .func_i (func_in),
        .dec_o  (dec)
    );

    mac_mult #(.DW(DW), .AW(AW)) u_mult (
        .x_i        (x_in),
        .y_i        (y_in),
        .x_signed_i (dec.x_signed),
        .y_signed_i (dec.y_signed),
        .frac_i     (!int_mode_in),
        .prod_o     (prod)
    );

    mac_accum #(.DW(DW), .AW(AW)) u_acc (
        .acc_i   (st_q.acc),
        .prod_i  (prod),
        .op_i    (dec.op),
        .round_i (dec.round),
        .res_o   (res),
        .ovf_o   (res_ovf)
    );

    always_comb begin
        st_d = st_q;
        if (dec.op != OP_IDLE) begin
            if (dest_fb_in) begin
                st_d.fb = res[2*DW-1:DW];
            end else begin
                st_d.acc = res;
                st_d.ovf = res_ovf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_hi_o  = st_q.acc[AW-1:2*DW];
    assign acc_mid_o = st_q.acc[2*DW-1:DW];
    assign acc_lo_o  = st_q.acc[DW-1:0];
    assign fb_o      = st_q.fb;
    assign ovf_o     = st_q.ovf;

    // R2: idle and out-of-range codes leave every output alone
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(func_in) == 5'd0 || $past(func_in[4]))
        |-> ($stable(st_q.acc) && $stable(fb_o) && $stable(ovf_o)));

    // R9: a feedback-destination write never disturbs the accumulator
    p_fb_keeps_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dest_fb_in) |-> ($stable(st_q.acc) && $stable(ovf_o)));

    // R9: an accumulator write never disturbs the feedback word
    p_acc_keeps_fb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dest_fb_in) |-> $stable(fb_o));

    // R8: a clear flag means the guard byte is a pure sign extension
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_o |-> (acc_hi_o == {GW{acc_mid_o[DW-1]}}));

endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] x_in = '0;
    logic [15:0] y_in = '0;
    logic [4:0]  func_in = '0;
    logic        int_mode_in = 1'b0;
    logic        dest_fb_in = 1'b0;
    logic [7:0]  acc_hi_o;
    logic [15:0] acc_mid_o;
    logic [15:0] acc_lo_o;
    logic [15:0] fb_o;
    logic        ovf_o;

    int checks = 0;
    int fails  = 0;

    logic [39:0] exp_acc = '0;
    logic [15:0] exp_fb  = '0;
    logic        exp_ovf = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mac_unit dut (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in), .func_in(func_in),
        .int_mode_in(int_mode_in), .dest_fb_in(dest_fb_in),
        .acc_hi_o(acc_hi_o), .acc_mid_o(acc_mid_o), .acc_lo_o(acc_lo_o),
        .fb_o(fb_o), .ovf_o(ovf_o)
    );

    function automatic logic [39:0] ref_result(input logic [4:0] f, input logic [15:0] x,
                                               input logic [15:0] y, input logic im,
                                               input logic [39:0] acc);
        longint px, py, pr, a;
        logic   xs, ys, rnd, tie;
        logic [1:0] kind;
        if (f[3:2] == 2'b00) begin
            kind = f[1:0]; rnd = 1'b1; xs = 1'b1; ys = 1'b1;
        end else begin
            kind = f[3:2]; rnd = 1'b0; xs = !f[1]; ys = !f[0];
        end
        px = xs ? longint'($signed(x)) : longint'({48'd0, x});
        py = ys ? longint'($signed(y)) : longint'({48'd0, y});
        pr = px * py;
        if (!im) pr = pr * 2;
        if (kind == 2'b01)      a = pr;
        else if (kind == 2'b10) a = longint'($signed(acc)) + pr;
        else                    a = longint'($signed(acc)) - pr;
        if (rnd) begin
            tie = (a[15:0] == 16'h8000);
            a = a + 64'sd32768;
            if (tie) a[16] = 1'b0;
        end
        return a[39:0];
    endfunction

    task automatic compare(input string tag);
        logic [39:0] got;
        got = {acc_hi_o, acc_mid_o, acc_lo_o};
        checks++;
        if (got !== exp_acc || fb_o !== exp_fb || ovf_o !== exp_ovf) begin
            fails++;
            $display("FAIL %s: acc=%010h fb=%04h ovf=%0b expected acc=%010h fb=%04h ovf=%0b",
                     tag, got, fb_o, ovf_o, exp_acc, exp_fb, exp_ovf);
        end
    endtask

    task automatic issue(input logic [4:0] f, input logic [15:0] x, input logic [15:0] y,
                         input logic im, input logic fbd, input string tag);
        logic [39:0] r;
        @(negedge clk);
        func_in = f; x_in = x; y_in = y; int_mode_in = im; dest_fb_in = fbd;
        if (f != 5'd0 && !f[4]) begin
            r = ref_result(f, x, y, im, exp_acc);
            if (fbd) exp_fb = r[31:16];
            else begin
                exp_acc = r;
                exp_ovf = !((&r[39:31]) || !(|r[39:31]));
            end
        end
        @(negedge clk);
        func_in = 5'd0;
        compare(tag);
    endtask

    task automatic expect_acc(input logic [39:0] v, input string tag);
        checks++;
        if ({acc_hi_o, acc_mid_o, acc_lo_o} !== v) begin
            fails++;
            $display("FAIL %s: acc=%010h expected %010h", tag,
                     {acc_hi_o, acc_mid_o, acc_lo_o}, v);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");
    endtask

    task automatic t_sign_modes;
        issue(5'b00111, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R4 R5 UU integer");
        expect_acc(40'h00FFFE0001, "R5 UU literal");
        issue(5'b00101, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R4 SU integer");
        expect_acc(40'hFFFFFF0001, "R10 SU part mapping");
        issue(5'b00110, 16'h8000, 16'hFFFF, 1'b1, 1'b0, "R4 US integer");
        issue(5'b00100, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R4 SS integer");
        issue(5'b00101, 16'h8000, 16'h0003, 1'b1, 1'b0, "R4 SU small Y");
    endtask

    task automatic t_alignment;
        issue(5'b00100, 16'h4000, 16'h4000, 1'b0, 1'b0, "R6 fractional shift");
        expect_acc(40'h0020000000, "R6 fractional literal");
        issue(5'b00100, 16'h4000, 16'h4000, 1'b1, 1'b0, "R6 integer no shift");
        issue(5'b00100, 16'h8000, 16'h8000, 1'b0, 1'b0, "R8 frac -1*-1 overflow");
    endtask

    task automatic t_accumulate;
        issue(5'b00100, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, "R4 load");
        for (int i = 0; i < 4; i++)
            issue(5'b01000, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, "R4 R8 add into guard");
        for (int i = 0; i < 5; i++)
            issue(5'b01100, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, "R4 R8 subtract back");
        issue(5'b01011, 16'hFFFF, 16'h0002, 1'b1, 1'b0, "R4 UU add");
        issue(5'b01110, 16'h8000, 16'h0001, 1'b1, 1'b0, "R4 US subtract");
    endtask

    task automatic t_rounding;
        issue(5'b00001, 16'h0001, 16'h8000, 1'b1, 1'b0, "R3 R7 tie odd mid");
        expect_acc(40'h0000000000, "R7 tie to even up");
        issue(5'b00001, 16'h0003, 16'h8000, 1'b1, 1'b0, "R3 R7 tie even mid");
        expect_acc(40'hFFFFFE0000, "R7 tie to even down");
        issue(5'b00001, 16'h0001, 16'h4001, 1'b1, 1'b0, "R7 non-tie");
        expect_acc(40'h000000C001, "R7 non-tie literal");
        issue(5'b00010, 16'h1234, 16'h5678, 1'b0, 1'b0, "R3 rounded add");
        issue(5'b00011, 16'hF00D, 16'h0BAD, 1'b0, 1'b0, "R3 rounded subtract");
    endtask

    task automatic t_idle_codes;
        issue(5'b00000, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, "R2 code zero");
        issue(5'b10011, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, "R2 bit4 code");
        issue(5'b11111, 16'h1111, 16'h2222, 1'b1, 1'b1, "R2 bit4 code fb dest");
    endtask

    task automatic t_feedback;
        issue(5'b00100, 16'h0100, 16'h0100, 1'b1, 1'b0, "R9 preload");
        issue(5'b01000, 16'h4000, 16'h2000, 1'b0, 1'b1, "R9 fb from accumulate");
        issue(5'b00100, 16'h8000, 16'h8000, 1'b0, 1'b1, "R9 fb keeps ovf");
        issue(5'b01000, 16'h0001, 16'h0001, 1'b1, 1'b0, "R9 acc after fb");
    endtask

    initial begin
        t_reset();
        t_sign_modes();
        t_alignment();
        t_accumulate();
        t_rounding();
        t_idle_codes();
        t_feedback();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule